// File: doc/BRIEF.md
# Nonlinear Carry-Select Adder

This block adds two 64-bit unsigned operands and returns the 64-bit sum together with the carry out of the top bit. It is purely combinational. It has no clock, no reset and no registers, so a result is valid as soon as the operands have settled.

The operand is cut into nine sections whose widths grow from the least significant end: 4, 4, 5, 6, 7, 8, 9, 10 and 11 bits. The lowest section is a single ripple adder with its carry-in tied to zero. Every higher section holds two ripple adders. One assumes an incoming carry of 0 and the other assumes 1, and both run in parallel with everything below them. The true carry leaving the section beneath then steers a multiplexer that picks the section's sum bits and its carry-out.

Because the sections widen as the select carry arrives later, each section's own ripple finishes at about the moment its select signal becomes valid. The section list is a parameter, and its entries must add up to the operand width.

Top module: `csel_nl_adder`

## Requirements
- R1: `sum` equals the low 64 bits of the unsigned sum `opa + opb`, for any pair of operands.
- R2: `carry_out` equals bit 64 of the 65-bit unsigned sum `opa + opb`; two all-ones operands give `sum` = all ones except bit 0 cleared, and `carry_out` = 1.
- R3: A carry produced in the lowest section travels through every higher section; all-ones plus one gives `sum` = 0 and `carry_out` = 1.
- R4: A carry produced at the top of any section reaches the next section's first bit. The section boundaries sit at bit positions 4, 8, 13, 19, 26, 34, 43 and 53. For each boundary position p, operands (2^p − 1) and 1 give `sum` = 2^p.
- R5: A carry entering a section whose operand bits are all zero stops there. For a boundary p, operands 2^(p−1) and 2^(p−1) give `sum` = 2^p, with no other bit set and `carry_out` = 0.
- R6: The lowest section adds with a carry-in of zero, so zero plus zero gives `sum` = 0 and `carry_out` = 0, and 1 plus 0 gives 1.
- R7: A carry propagates only when all the bits below it propagate. Alternating bit patterns that propagate in some sections and generate or kill in others give the arithmetic sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | First unsigned operand |
| opb | input | 64 | Second unsigned operand |
| sum | output | 64 | Low 64 bits of opa + opb |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
Every result is due zero clock cycles after its stimulus, because the path from operands to outputs holds no register. The bench uses a clock only to pace the work. It applies each operand pair on a falling edge and pushes the expected pair onto a queue. The monitor pops the entry and compares it at the next rising edge, half a period later, when the combinational paths have long since settled. The expected values come from a plain 65-bit behavioural addition. The directed vectors place a carry across each section boundary, and random vectors fill in the rest.

// File: rtl/csel_pkg.sv
// Package: shared configuration of the nonlinear carry-select adder.
// Holds the default operand width and the default section list.
// Assumes the list runs from the least significant section upward.
package csel_pkg;
    parameter int unsigned CS_DEF_WIDTH = 64;
    parameter int unsigned CS_DEF_NSEC  = 9;
    typedef int unsigned sec_list_t [CS_DEF_NSEC];
    parameter sec_list_t CS_DEF_SECW = '{4, 4, 5, 6, 7, 8, 9, 10, 11};
endpackage

// File: rtl/csel_ripple.sv
// Module: csel_ripple
// A W-bit ripple-carry adder built from propagate/generate full-adder cells.
// Assumes W >= 1. It is purely combinational.
module csel_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W:0]   chain;

    assign chain[0] = cin;

    // One full-adder cell per bit: sum bit and the carry into the next bit.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign prop[i]     = a[i] ^ b[i];
        assign gen[i]      = a[i] & b[i];
        assign sum[i]      = prop[i] ^ chain[i];
        assign chain[i+1]  = gen[i] | (prop[i] & chain[i]);
    end

    assign cout = chain[W];

    // Check the ripple chain against arithmetic addition.
    always_comb begin
        assert_ripple_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("ripple cell chain disagrees with arithmetic sum");
    end
endmodule

// File: rtl/csel_section.sv
// Module: csel_section
// One carry-select section. Two ripple adders precompute the results for
// carry-in 0 and carry-in 1. The real incoming carry picks one of them.
// Assumes `cin` arrives later than the local ripples settle.
module csel_section #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] sum_c0;
    logic [W-1:0] sum_c1;
    logic         co_c0;
    logic         co_c1;

    csel_ripple #(.W(W)) u_assume0 (
        .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(co_c0)
    );

    csel_ripple #(.W(W)) u_assume1 (
        .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(co_c1)
    );

    // Select the precomputed sum bits and carry-out with the real carry.
    always_comb begin
        if (cin) begin
            sum  = sum_c1;
            cout = co_c1;
        end else begin
            sum  = sum_c0;
            cout = co_c0;
        end
    end

    // Check that the selected section result equals a + b + cin, and that
    // the carry-out is monotonic in the carry-in.
    always_comb begin
        assert_section_sum_R4: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("section select produced a wrong result");
        assert_carry_monotone_R7: assert (!(co_c0 && !co_c1))
            else $error("carry for assumed 0 set while carry for assumed 1 clear");
    end
endmodule

// File: rtl/csel_nl_adder.sv
// Module: csel_nl_adder (top)
// Combinational nonlinear carry-select adder. Sections of growing width are
// listed in SEC_W from the least significant end. Section 0 is a single ripple
// adder with carry-in 0. Every later section is a csel_section whose select
// is the carry-out of the section below.
// Assumes the entries of SEC_W sum to WIDTH. This is checked at elaboration.
module csel_nl_adder
    import csel_pkg::*;
#(
    parameter int unsigned WIDTH = CS_DEF_WIDTH,
    parameter int unsigned NSEC  = CS_DEF_NSEC,
    parameter int unsigned SEC_W [NSEC] = CS_DEF_SECW
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    // Lowest bit index of section k.
    function automatic int unsigned sec_lo(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned j = 0; j < k; j++) acc += SEC_W[j];
        return acc;
    endfunction

    localparam int unsigned TOTAL_W = sec_lo(NSEC);

    if (TOTAL_W != WIDTH) begin : g_bad_list
        $error("section widths do not add up to WIDTH");
    end

    logic [NSEC:0] sec_carry;

    assign sec_carry[0] = 1'b0;

    // Build the section chain; the first section needs only one ripple adder.
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        localparam int unsigned LO = sec_lo(k);
        localparam int unsigned SW = SEC_W[k];
        if (k == 0) begin : g_head
            csel_ripple #(.W(SW)) u_head (
                .a    (opa[LO +: SW]),
                .b    (opb[LO +: SW]),
                .cin  (1'b0),
                .sum  (sum[LO +: SW]),
                .cout (sec_carry[k+1])
            );
        end else begin : g_body
            csel_section #(.W(SW)) u_sect (
                .a    (opa[LO +: SW]),
                .b    (opb[LO +: SW]),
                .cin  (sec_carry[k]),
                .sum  (sum[LO +: SW]),
                .cout (sec_carry[k+1])
            );
        end
    end

    assign carry_out = sec_carry[NSEC];

    // Whole-adder checks at the ports.
    always_comb begin
        assert_total_sum_R1: assert (sum == opa + opb)
            else $error("sum differs from operand total");
        assert_carry_out_R2: assert ({carry_out, sum} == ({1'b0, opa} + {1'b0, opb}))
            else $error("carry_out differs from bit WIDTH of operand total");
        assert_zero_in_R6: assert (!((opa == '0) && (opb == '0)) || ((sum == '0) && !carry_out))
            else $error("zero operands gave nonzero result");
    end
endmodule

// File: tb/csel_nl_adder_bench.sv
// Scoreboard bench: a driver task applies operands on the falling edge and
// queues the expected result; a monitor pops and compares on the rising edge.
module csel_nl_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    typedef struct {
        logic [W-1:0] exp_sum;
        logic         exp_co;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] sum;
    logic         carry_out;

    exp_t  sb_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    csel_nl_adder u_csel_nl_adder (
        .opa(opa), .opb(opb), .sum(sum), .carry_out(carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one pair and queue its behavioural result.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [W:0] full;
        exp_t       item;
        @(negedge clk);
        opa  = a;
        opb  = b;
        full = {1'b0, a} + {1'b0, b};
        item.exp_sum = full[W-1:0];
        item.exp_co  = full[W];
        item.tag     = tag;
        sb_q.push_back(item);
    endtask

    // Monitor: compare the oldest queued expectation at the rising edge.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (sum !== it.exp_sum || carry_out !== it.exp_co) begin
                n_fail++;
                $display("FAIL %s: got sum=%h co=%b, expected sum=%h co=%b",
                         it.tag, sum, carry_out, it.exp_sum, it.exp_co);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int bnd [8] = '{4, 8, 13, 19, 26, 34, 43, 53};
        logic [W-1:0] ones;
        ones = '1;

        // R6: zero inputs, and carry-in of the lowest section is zero.
        drive('0, '0, "R6 zero");
        drive(64'd1, '0, "R6 one plus zero");
        // R3: carry from the lowest bit through every section.
        drive(ones, 64'd1, "R3 full propagate");
        drive(64'd1, ones, "R3 full propagate swapped");
        // R2: carry out of the top bit.
        drive(ones, ones, "R2 all ones");
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R2 top bits");
        // R4 and R5: every section boundary.
        foreach (bnd[i]) begin
            drive((64'd1 << bnd[i]) - 64'd1, 64'd1, "R4 boundary ripple in");
            drive(64'd1 << (bnd[i]-1), 64'd1 << (bnd[i]-1), "R5 boundary generate");
        end
        // R7: mixed propagate, generate and kill patterns.
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, "R7 propagate all");
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5556, "R7 propagate with seed");
        drive(64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F10, "R7 nibble chain");
        drive(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211, "R7 complement plus one");
        // R1: random operands.
        for (int n = 0; n < 3000; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, "R1 random");
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule